// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block collects the four interrupt pins (A to D) of each device slot on a PCI bus and steers them onto sixteen level-sensitive inputs of a legacy interrupt controller. It works in two stages. First, every pin is rotated by its slot number onto one of four shared lines, so neighbouring slots spread their pin A requests across different lines. Second, each shared line has a programmable byte that picks its target controller input, or turns the line off.

Several shared lines may target the same controller input. That input is then the OR of all of them, and it stays high until every contributor has released it. The outputs are registered. A routing byte that is rewritten moves the request from the old target to the new one at a single clock edge.

Top module: `pirq_steer`

## Requirements
- R1: After reset, all four routing bytes read 0x80 and every bit of `irq_o` is low.
- R2: A write to the routing byte at `cfg_addr_i` (0 to 3, one per shared line) takes effect at that clock edge. `cfg_rdata_o` then returns exactly the value written, all eight bits included. A byte that is not written keeps its value.
- R3: The request for pin p (0 = A … 3 = D) of slot s sits at `req_i[s*4+p]`. It drives shared line (p + s − 1) mod 4.
- R4: If bit 7 of a routing byte is clear and a shared line is high, output `irq_o[n]` is driven high, where n is the value of bits 3:0. Bits 6:4 have no effect.
- R5: A routing byte with bit 7 set drives no output, whatever its line level.
- R6: A routing byte that selects output 0, 1, 2, 8 or 13 behaves as disabled, so those outputs never go high.
- R7: Each output is the OR of every enabled shared line that targets it. A shared line is the OR of every request mapped onto it. An output stays high until all contributors are low.
- R8: When a routing byte is rewritten while its line is high, the old target falls and the new target rises at the same clock edge.
- R9: `irq_o` reflects `req_i` as sampled at a rising edge, using the routing bytes as they stood before that edge. A write at edge k therefore changes `irq_o` at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SLOTS*4 | Per-slot, per-pin interrupt request levels |
| cfg_we_i | input | 1 | Routing byte write strobe |
| cfg_addr_i | input | 2 | Routing byte index, for both write and read |
| cfg_wdata_i | input | 8 | Routing byte write data |
| cfg_rdata_o | output | 8 | Routing byte at `cfg_addr_i` |
| irq_o | output | NUM_IRQ | Level interrupt outputs to the controller |

## Verification
The bench runs every pin of every slot alone, to catch a rotation that is off by one or runs the wrong way. Such an error would light the output of a neighbouring line.

All 256 values of one routing byte are written and read back. This exposes a design that:
- decodes bits 6:4;
- lets a reserved number through;
- ignores the disable bit;
- stores less than the full byte.

A full sweep of all 65536 request patterns runs over a configuration in which two lines share one output and one line is disabled. A design that lets the last writer win, instead of ORing the sources, fails this sweep. A rewrite of a routing byte while its line is active catches two faults: a stale old target, and an output that moves one edge early.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned PIN_CNT  = 4;
  localparam int unsigned PIRQ_CNT = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFF_BIT  = 7;
  localparam logic [BYTE_W-1:0] ROUTE_RST = 8'h80;

  // slot-based pin rotation; +3 is -1 modulo 4
  function automatic logic [1:0] pirq_of(int unsigned slot, int unsigned pin);
    return 2'((pin + slot + PIRQ_CNT - 1) % PIRQ_CNT);
  endfunction
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned REQ_W = NUM_SLOTS * PIN_CNT
) (
  input  logic [REQ_W-1:0]    req_i,
  output logic [PIRQ_CNT-1:0] lvl_o
);
  for (genvar q = 0; q < PIRQ_CNT; q++) begin : g_line
    logic [REQ_W-1:0] hit;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
        assign hit[s*PIN_CNT+p] = (pirq_of(s, p) == 2'(q)) ? req_i[s*PIN_CNT+p] : 1'b0;
      end
    end
    assign lvl_o[q] = |hit;
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [1:0]                     addr_i,
  input  logic [BYTE_W-1:0]              wdata_i,
  output logic [BYTE_W-1:0]              rdata_o,
  output logic [PIRQ_CNT-1:0]            off_o,
  output logic [PIRQ_CNT-1:0][SEL_W-1:0] sel_o
);
  logic [PIRQ_CNT-1:0][BYTE_W-1:0] route_q;

  for (genvar k = 0; k < PIRQ_CNT; k++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       route_q[k] <= ROUTE_RST;
      else if (we_i && addr_i == 2'(k)) route_q[k] <= wdata_i;
    end
    assign off_o[k] = route_q[k][OFF_BIT];
    assign sel_o[k] = route_q[k][SEL_W-1:0];
  end

  assign rdata_o = route_q[addr_i];

  // R2
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> route_q[$past(addr_i)] == $past(wdata_i));
  // R2
  route_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(route_q));
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge
  import pirq_pkg::*;
#(
  parameter int unsigned     NUM_IRQ   = 16,
  parameter logic [NUM_IRQ-1:0] RSVD_MASK = 16'h2107,
  localparam int unsigned    SEL_W     = $clog2(NUM_IRQ)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [PIRQ_CNT-1:0]            lvl_i,
  input  logic [PIRQ_CNT-1:0]            off_i,
  input  logic [PIRQ_CNT-1:0][SEL_W-1:0] sel_i,
  output logic [NUM_IRQ-1:0]             irq_o
);
  logic [PIRQ_CNT-1:0][NUM_IRQ-1:0] fan;
  logic [NUM_IRQ-1:0]               irq_d;

  for (genvar k = 0; k < PIRQ_CNT; k++) begin : g_fan
    logic live;
    assign live   = !off_i[k] && !RSVD_MASK[sel_i[k]] && lvl_i[k];
    assign fan[k] = live ? (NUM_IRQ'(1) << sel_i[k]) : '0;
  end

  always_comb begin
    irq_d = '0;
    for (int k = 0; k < PIRQ_CNT; k++) irq_d |= fan[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= irq_d;
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i == '0 |=> irq_o == '0);
  // R6
  rsvd_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & RSVD_MASK) == '0);
  // R7
  fan_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(irq_o) <= $countones($past(lvl_i)));
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_pkg::*;
#(
  parameter int unsigned        NUM_SLOTS = 4,
  parameter int unsigned        NUM_IRQ   = 16,
  parameter logic [NUM_IRQ-1:0] RSVD_MASK = 16'h2107,
  localparam int unsigned       REQ_W     = NUM_SLOTS * PIN_CNT,
  localparam int unsigned       SEL_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REQ_W-1:0]   req_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [BYTE_W-1:0]  cfg_wdata_i,
  output logic [BYTE_W-1:0]  cfg_rdata_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [PIRQ_CNT-1:0]            lvl;
  logic [PIRQ_CNT-1:0]            off;
  logic [PIRQ_CNT-1:0][SEL_W-1:0] sel;

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) i_swizzle (
    .req_i (req_i),
    .lvl_o (lvl)
  );

  pirq_route_regs #(.SEL_W(SEL_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .off_o   (off),
    .sel_o   (sel)
  );

  pirq_merge #(.NUM_IRQ(NUM_IRQ), .RSVD_MASK(RSVD_MASK)) i_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .off_i  (off),
    .sel_i  (sel),
    .irq_o  (irq_o)
  );

  // R3
  req_reach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (lvl != '0));
endmodule

// File: tb/test_pirq_steer.sv
module test_pirq_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [15:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rt [4];

  always #2.5 clk_i = ~clk_i;

  pirq_steer i_pirq_steer (.*);

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] v);
    cfg_we_i = 1'b1; cfg_addr_i = 2'(a); cfg_wdata_i = v;
    tick();
    cfg_we_i = 1'b0;
    rt[a] = v;
  endtask

  function automatic bit rsvd(int n);
    return n == 0 || n == 1 || n == 2 || n == 8 || n == 13;
  endfunction

  function automatic logic [15:0] model(logic [15:0] rq);
    logic [3:0]  pl = '0;
    logic [15:0] m  = '0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        if (rq[s*4+p]) pl[(p + s + 3) % 4] = 1'b1;
    for (int k = 0; k < 4; k++)
      if (pl[k] && !rt[k][7] && !rsvd(int'(rt[k][3:0]))) m[rt[k][3:0]] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) rt[k] = 8'h80;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    // R1
    chk("R1 irq", irq_o, 16'h0);
    for (int k = 0; k < 4; k++) begin
      cfg_addr_i = 2'(k); #1;
      chk("R1 rd", 16'(cfg_rdata_o), 16'h80);
    end

    // R3: single pin per slot, distinct targets 3..6
    for (int k = 0; k < 4; k++) wr(k, 8'(3 + k));
    for (int b = 0; b < 16; b++) begin
      req_i = 16'(1) << b;
      tick();
      chk("R3 swizzle", irq_o, 16'(1) << (3 + ((b % 4) + (b / 4) + 3) % 4));
    end
    req_i = '0; tick();

    // R2 R4 R5 R6: all byte values on line 0 (slot 1 pin A)
    for (int k = 1; k < 4; k++) wr(k, 8'h80);
    req_i = 16'h0010;
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'(v));
      cfg_addr_i = 2'd0; #1;
      chk("R2 readback", 16'(cfg_rdata_o), 16'(v));
      tick();
      chk("R4/R5/R6 route", irq_o, model(req_i));
    end
    // R2: other bytes untouched
    for (int k = 1; k < 4; k++) begin
      cfg_addr_i = 2'(k); #1;
      chk("R2 keep", 16'(cfg_rdata_o), 16'h80);
    end
    req_i = '0; tick();

    // R7: shared target and disabled line, full sweep
    wr(0, 8'h0A); wr(1, 8'h7A); wr(2, 8'h0B); wr(3, 8'h8B);
    tick();
    for (int v = 0; v < 65536; v++) begin
      req_i = 16'(v);
      tick();
      if (irq_o !== model(req_i)) chk("R7 merge", irq_o, model(req_i));
      else n_chk++;
    end
    // R7: shared output held until last contributor drops
    req_i = 16'h0030; tick();
    chk("R7 both", irq_o, 16'h0400);
    req_i = 16'h0020; tick();
    chk("R7 one left", irq_o, 16'h0400);
    req_i = 16'h0000; tick();
    chk("R7 released", irq_o, 16'h0000);

    // R8 R9: retarget an active line
    wr(0, 8'h80); wr(1, 8'h0A); wr(2, 8'h80);
    req_i = 16'h0020; tick();
    chk("R8 before", irq_o, 16'h0400);
    wr(1, 8'h0C);
    chk("R9 write latency", irq_o, 16'h0400);
    tick();
    chk("R8 moved", irq_o, 16'h1000);
    // R9: input latency
    req_i = '0; #1;
    chk("R9 hold", irq_o, 16'h1000);
    tick();
    chk("R9 drop", irq_o, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule